// File: doc/BRIEF.md
# Analog test bus interface controller

This block is the digital control logic that sits behind the two external analog test pins and the two internal analog measurement buses of a mixed-signal boundary-scan chip. It owns a four-bit control register that is shifted serially from `scan_in` to `scan_out`. The register is loaded, shifted and committed under strobes from a TAP controller that lives outside the block. The committed (update) value and the current decoded instruction together choose one of ten switch patterns, P0 to P9. The chosen pattern drives ten switch-enable outputs, S1 to S10. These outputs connect the test pins to the buses, isolate them, drive them to fixed levels, or clamp the buses.

For interconnect testing, the block takes one comparator result per test pin. Each result is 1 when the pin voltage is above the threshold. These results are captured into the low bits of the control register, so they can be shifted out. The switch enables come from a register. They move only on the edge after a commit or an instruction change. While the CLAMP instruction is active they hold their value.

Top module: `tbic_ctrl`

## Requirements
- R1: An active-high synchronous `rst` clears the shift stage and the update stage to 0000 and sets `sw_en` to the P0 value 10'h0C0. `scan_out` reads 0 after reset, and with EXTEST selected `sw_en` stays at P0 after reset is released.
- R2: When `shift_en` is high, the register shifts one place toward bit 0 on each clock: `scan_in` enters bit 3 and `scan_out` shows bit 0. After four shifts the register holds the four bits that were shifted in, first bit in bit 0.
- R3: When `capture_en` is high, bit i of the register (i = 0 for test pin 1, i = 1 for test pin 2) is loaded from `pin_cmp[i]`. Bits 3:2 are loaded from the update stage. Capture takes priority over shift.
- R4: `update_en` copies the shift stage into the update stage. `sw_en` reflects a commit or an instruction change on the clock edge after it, and it does not change during capture or shift.
- R5: With instruction code 3'd1 (EXTEST), control values 0 to 7 select P0 to P7 in order, 9 selects P8 and 10 selects P9.
- R6: With EXTEST, control values 8 and 11 to 15 select P0.
- R7: With instruction code 3'd2 (PROBE), control values 0 to 3 select P0 to P3, and values 4 to 15 select P0.
- R8: Instruction code 3'd3 (HIGHZ) and every code other than 1, 2 and 4 (for example 0 = BYPASS, 5, 6, 7) force P0 regardless of the control value.
- R9: While the instruction code is 3'd4 (CLAMP), `sw_en` holds its present value even across a commit. On leaving CLAMP it follows the current update value on the next edge.
- R10: Bit k of `sw_en` is switch S(k+1). S1 connects AT1 to AB1, S2 connects AT2 to AB2, S3 and S4 drive AT1 high and low, S5 and S6 drive AT2 high and low, S7 and S8 clamp AB1 and AB2, S9 joins AT1 to AB2, and S10 joins AT2 to AB1. The pattern values are P0=0C0, P1=042, P2=081, P3=003, P4=0E8, P5=0D8, P6=0E4, P7=0D4, P8=100, P9=200 (hex). A pin is never driven high and low at once, and AT1 is never driven while it is connected to AB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| capture_en | input | 1 | Capture strobe from the TAP controller |
| shift_en | input | 1 | Shift strobe from the TAP controller |
| update_en | input | 1 | Update (commit) strobe from the TAP controller |
| scan_in | input | 1 | Serial data into the control register |
| instr | input | 3 | Decoded instruction class (1 EXTEST, 2 PROBE, 3 HIGHZ, 4 CLAMP, others isolate) |
| pin_cmp | input | PIN_N (2) | Threshold comparator result for each external test pin |
| scan_out | output | 1 | Serial data out of the control register (bit 0) |
| sw_en | output | SW_N (10) | Switch enables S1..S10 |

## Verification
The hardest case to reach from the ports is a commit that arrives while CLAMP is active. The new update value is stored but must not reach the switches, and it must then surface in a single step when CLAMP is released. The stimulus first commits a nonzero EXTEST pattern and switches to CLAMP. It then shifts and commits a different value and checks that the switches hold. Finally it returns to EXTEST and checks that the stored value appears one edge later. A second hard case is checking that the capture loads the comparator bits and the live update bits. For this, a nonzero pattern is committed first, so that the upper captured bits are distinct from reset, and the captured word is read back bit by bit through `scan_out`.

// File: rtl/tbic_pkg.sv
package tbic_pkg;

  localparam int SW_N = 10;

  localparam logic [2:0] INS_BYPASS = 3'd0;
  localparam logic [2:0] INS_EXTEST = 3'd1;
  localparam logic [2:0] INS_PROBE  = 3'd2;
  localparam logic [2:0] INS_HIGHZ  = 3'd3;
  localparam logic [2:0] INS_CLAMP  = 3'd4;

  typedef enum logic [3:0] {
    PAT0 = 4'd0, PAT1 = 4'd1, PAT2 = 4'd2, PAT3 = 4'd3, PAT4 = 4'd4,
    PAT5 = 4'd5, PAT6 = 4'd6, PAT7 = 4'd7, PAT8 = 4'd8, PAT9 = 4'd9
  } pat_e;

  // bit k = switch S(k+1)
  // S1 AT1-AB1, S2 AT2-AB2, S3/S4 AT1 hi/lo, S5/S6 AT2 hi/lo,
  // S7/S8 clamp AB1/AB2, S9 AT1-AB2, S10 AT2-AB1
  function automatic logic [SW_N-1:0] pat_switches(input pat_e p);
    logic [SW_N-1:0] s;
    case (p)
      PAT1:    s = 10'h042;
      PAT2:    s = 10'h081;
      PAT3:    s = 10'h003;
      PAT4:    s = 10'h0E8;
      PAT5:    s = 10'h0D8;
      PAT6:    s = 10'h0E4;
      PAT7:    s = 10'h0D4;
      PAT8:    s = 10'h100;
      PAT9:    s = 10'h200;
      default: s = 10'h0C0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tbic_scan_reg.sv
module tbic_scan_reg #(
  parameter int W     = 4,
  parameter int PIN_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             scan_in,
  input  logic [PIN_N-1:0] pin_cmp,
  output logic             scan_out,
  output logic [W-1:0]     upd_q
);

  logic [W-1:0] sh_q;
  logic [W-1:0] cap_val;

  // low bits take the comparator results, upper bits report the live update stage
  always_comb begin
    cap_val = upd_q;
    for (int i = 0; i < PIN_N; i++) begin
      cap_val[i] = pin_cmp[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      upd_q <= '0;
    end else begin
      if (capture_en) begin
        sh_q <= cap_val;
      end else if (shift_en) begin
        sh_q <= {scan_in, sh_q[W-1:1]};
      end
      if (update_en) begin
        upd_q <= sh_q;
      end
    end
  end

  assign scan_out = sh_q[0];

endmodule

// File: rtl/tbic_pattern_dec.sv
module tbic_pattern_dec
  import tbic_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2:0]   instr,
  input  logic [W-1:0] code,
  output pat_e         pat
);

  always_comb begin
    pat = PAT0;
    case (instr)
      INS_EXTEST: begin
        if (code < W'(8)) begin
          pat = pat_e'(code[3:0]);
        end else if (code == W'(9)) begin
          pat = PAT8;
        end else if (code == W'(10)) begin
          pat = PAT9;
        end
      end
      INS_PROBE: begin
        if (code < W'(4)) begin
          pat = pat_e'(code[3:0]);
        end
      end
      default: pat = PAT0;
    endcase
  end

endmodule

// File: rtl/tbic_ctrl.sv
module tbic_ctrl
  import tbic_pkg::*;
#(
  parameter int CTL_W = 4,
  parameter int PIN_N = 2,
  parameter int SW_N  = tbic_pkg::SW_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             scan_in,
  input  logic [2:0]       instr,
  input  logic [PIN_N-1:0] pin_cmp,
  output logic             scan_out,
  output logic [SW_N-1:0]  sw_en
);

  logic [CTL_W-1:0] upd_q;
  pat_e             pat;
  logic [SW_N-1:0]  sw_q;

  tbic_scan_reg #(.W(CTL_W), .PIN_N(PIN_N)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .scan_in    (scan_in),
    .pin_cmp    (pin_cmp),
    .scan_out   (scan_out),
    .upd_q      (upd_q)
  );

  tbic_pattern_dec #(.W(CTL_W)) u_dec (
    .instr (instr),
    .code  (upd_q),
    .pat   (pat)
  );

  // registered switch enables; CLAMP freezes them in place
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= SW_N'(pat_switches(PAT0));
    end else if (instr != INS_CLAMP) begin
      sw_q <= SW_N'(pat_switches(pat));
    end
  end

  assign sw_en = sw_q;

endmodule

// File: rtl/tbic_ctrl_chk.sv
module tbic_ctrl_chk #(
  parameter int SW_N = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            update_en,
  input logic [2:0]      instr,
  input logic [SW_N-1:0] sw_en
);

  a_r1_reset_iso: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sw_en == SW_N'(10'h0C0)));

  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(update_en) && $stable(instr)) |=> $stable(sw_en));

  a_r8_highz_iso: assert property (@(posedge clk) disable iff (rst)
    (instr == tbic_pkg::INS_HIGHZ) |=> (sw_en == SW_N'(10'h0C0)));

  a_r9_clamp_hold: assert property (@(posedge clk) disable iff (rst)
    (instr == tbic_pkg::INS_CLAMP) |=> $stable(sw_en));

  a_r10_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(sw_en[2] && sw_en[3]) && !(sw_en[4] && sw_en[5]) &&
    !(sw_en[0] && (sw_en[2] || sw_en[3])));

endmodule

bind tbic_ctrl tbic_ctrl_chk #(.SW_N(SW_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .update_en (update_en),
  .instr     (instr),
  .sw_en     (sw_en)
);

// File: tb/tbic_ctrl_tb.sv
`timescale 1ns/1ps
module tbic_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       capture_en = 1'b0;
  logic       shift_en = 1'b0;
  logic       update_en = 1'b0;
  logic       scan_in = 1'b0;
  logic [2:0] instr = 3'd1;
  logic [1:0] pin_cmp = 2'b00;
  logic       scan_out;
  logic [9:0] sw_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  tbic_ctrl u_dut (
    .clk(clk), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .scan_in(scan_in), .instr(instr),
    .pin_cmp(pin_cmp), .scan_out(scan_out), .sw_en(sw_en)
  );

  // {instr, control value, expected switches}
  localparam int NV = 34;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {3'd1, 4'd0,  10'h0C0}, {3'd1, 4'd1,  10'h042}, {3'd1, 4'd2,  10'h081},
    {3'd1, 4'd3,  10'h003}, {3'd1, 4'd4,  10'h0E8}, {3'd1, 4'd5,  10'h0D8},
    {3'd1, 4'd6,  10'h0E4}, {3'd1, 4'd7,  10'h0D4}, {3'd1, 4'd8,  10'h0C0},
    {3'd1, 4'd9,  10'h100}, {3'd1, 4'd10, 10'h200}, {3'd1, 4'd11, 10'h0C0},
    {3'd1, 4'd12, 10'h0C0}, {3'd1, 4'd13, 10'h0C0}, {3'd1, 4'd14, 10'h0C0},
    {3'd1, 4'd15, 10'h0C0},
    {3'd1, 4'd3,  10'h003}, {3'd3, 4'd3,  10'h0C0}, {3'd1, 4'd5,  10'h0D8},
    {3'd0, 4'd5,  10'h0C0}, {3'd1, 4'd7,  10'h0D4}, {3'd5, 4'd7,  10'h0C0},
    {3'd1, 4'd9,  10'h100}, {3'd2, 4'd9,  10'h0C0}, {3'd2, 4'd1,  10'h042},
    {3'd2, 4'd2,  10'h081}, {3'd2, 4'd3,  10'h003}, {3'd2, 4'd0,  10'h0C0},
    {3'd2, 4'd3,  10'h003}, {3'd2, 4'd4,  10'h0C0}, {3'd2, 4'd3,  10'h003},
    {3'd6, 4'd3,  10'h0C0}, {3'd2, 4'd2,  10'h081}, {3'd7, 4'd2,  10'h0C0}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] ins, input logic [3:0] c);
    if (ins == 3'd1) return ((c < 4'd8 && c != 4'd8) || c == 4'd9 || c == 4'd10) ? "R5 extest" : "R6 extest-undef";
    if (ins == 3'd2) return "R7 probe";
    return "R8 isolate";
  endfunction

  task automatic shift_code(input logic [3:0] c);
    for (int i = 0; i < 4; i++) begin
      shift_en = 1'b1;
      scan_in  = c[i];
      @(negedge clk);
    end
    shift_en = 1'b0;
    scan_in  = 1'b0;
  endtask

  task automatic pulse_update();
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [3:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset switches", 16'(sw_en), 16'h0C0);
    chk("R1 reset scan_out", 16'(scan_out), 16'h0);
    @(negedge clk);
    chk("R1 idle after reset", 16'(sw_en), 16'h0C0);

    // table walk: R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      shift_code(VEC[v][13:10]);
      instr = VEC[v][16:14];
      pulse_update();
      @(negedge clk);
      chk(tag_of(VEC[v][16:14], VEC[v][13:10]), 16'(sw_en), 16'(VEC[v][9:0]));
    end

    // R4: instruction change takes one edge; shift leaves switches alone
    instr = 3'd1;
    @(negedge clk);
    chk("R4 instr change", 16'(sw_en), 16'h081);
    for (int i = 0; i < 4; i++) begin
      shift_en = 1'b1;
      scan_in  = i[0] ^ i[1] ? 1'b1 : 1'b0; // 0,1,1,0 -> value 6
      @(negedge clk);
      chk("R4 stable during shift", 16'(sw_en), 16'h081);
    end
    shift_en = 1'b0;
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
    chk("R4 one edge after commit", 16'(sw_en), 16'h081);
    @(negedge clk);
    chk("R5 P6 after commit", 16'(sw_en), 16'h0E4);

    // R9: clamp freezes across a commit, release follows update stage
    instr = 3'd4;
    @(negedge clk);
    chk("R9 clamp entry", 16'(sw_en), 16'h0E4);
    shift_code(4'd3);
    pulse_update();
    repeat (2) @(negedge clk);
    chk("R9 clamp hold over commit", 16'(sw_en), 16'h0E4);
    instr = 3'd1;
    @(negedge clk);
    chk("R9 clamp release", 16'(sw_en), 16'h003);

    // R3/R2: capture comparator bits plus update bits, read out serially
    shift_code(4'd7);
    pulse_update();
    @(negedge clk);
    chk("R5 P7 before capture", 16'(sw_en), 16'h0D4);
    pin_cmp = 2'b10;
    capture_en = 1'b1;
    shift_en   = 1'b1; // capture must win
    @(negedge clk);
    capture_en = 1'b0;
    shift_en   = 1'b0;
    chk("R4 stable during capture", 16'(sw_en), 16'h0D4);
    for (int i = 0; i < 4; i++) begin
      got[i]   = scan_out;
      shift_en = 1'b1;
      scan_in  = (i == 0 || i == 3);
      @(negedge clk);
    end
    shift_en = 1'b0;
    chk("R3 captured word", 16'(got), 16'h6);
    for (int i = 0; i < 4; i++) begin
      got[i]   = scan_out;
      shift_en = 1'b1;
      scan_in  = 1'b0;
      @(negedge clk);
    end
    shift_en = 1'b0;
    chk("R2 shift-through word", 16'(got), 16'h9);
    chk("R4 stable after shifting", 16'(sw_en), 16'h0D4);

    // R1: reset mid-operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-run", 16'(sw_en), 16'h0C0);
    @(negedge clk);
    chk("R1 update stage cleared", 16'(sw_en), 16'h0C0);
    chk("R1 scan_out cleared", 16'(scan_out), 16'h0);

    summary();
  end

endmodule